// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation analog-to-digital converter. Each conversion runs through a fixed cycle of fifteen clock periods, each advanced on the rising clock edge. The first three periods track the input while the comparator auto-zeroes. The next twelve periods try the result bits from the most significant down. For each trial the block drives a one-hot-plus-kept-bits pattern to the capacitor array and reads back one comparator bit. At the end of the last period the finished word moves into an output latch, and a data-ready flag marks the start of the following cycle.

An active-low start input selects how conversions are paced. Held low, it makes the sequencer free-run. Released during the first period, it makes the sequencer park in the second period with the input still tracking and the previous result still flagged. A later low level on start resumes the cycle at period three. When the block's clock comes from the on-chip oscillator, a clock-run output drops while parked so that the oscillator can stop. When the clock is supplied from outside, that output stays high. The latched word is presented as a data bus with a per-bit output-enable vector. The upper eight bits and the lower four bits each have their own active-low enable.

The block has no stream interface. Data-ready is a plain flag with no back-pressure: a word that is not read before the next capture is overwritten.

Top module: `sar_conv_seq`

## Requirements
- R1: With start held low, data-ready rises exactly once every 15 clock edges, on the edge that ends period 15.
- R2: In periods 1 to 3, track and auto-zero outputs are high and every capacitor select bit is 0.
- R3: In period 4, track is low and the capacitor select is 0x800 (only bit 11 set). In period 5, bit 11 holds the comparator result from period 4 and bit 10 is set.
- R4: Bits 10 down to 0 are resolved one per period in periods 5 to 15. With a comparator that reports (select <= analog code), the captured word equals that code.
- R5: The output latch loads only on the edge ending period 15 and holds its word unchanged through the whole following cycle.
- R6: Data-ready is high during period 1 only while free-running, and falls on the edge that ends period 1 when a conversion continues.
- R7: With start high at the end of period 1, the sequencer parks in period 2: tracking continues, data-ready stays high, the latch is unchanged, and with the internal clock source (clock-source select = 0) clock-run is low.
- R8: While parked, start low on a clock edge moves the sequencer to period 3 on that edge, clears data-ready and raises clock-run. The conversion then completes 13 edges later with the correct word.
- R9: With the external clock source (clock-source select = 1), clock-run stays high while parked, and a start resumes the cycle in the same way.
- R10: The upper enable low sets enable bits 11..4, the lower enable low sets enable bits 3..0, and a high enable clears its group. The data bus always carries the latch.
- R11: A synchronous active-low reset gives period 1 with tracking, a zero latch, data-ready low and clock-run high.
- R12: The start level during periods 2 to 15 of a running conversion has no effect on timing or result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_n | input | 1 | Start conversion, active low |
| clk_src_ext | input | 1 | 0 = internal oscillator, 1 = external clock |
| cmp_hi | input | 1 | Comparator result for the current trial |
| track_en | output | 1 | Capacitors connected to the analog input |
| autozero_en | output | 1 | Comparator auto-balance |
| cap_sel | output | 12 | Per-bit select: 1 = positive reference, 0 = negative |
| clk_run | output | 1 | Clock oscillator run enable |
| data_rdy | output | 1 | New result available |
| oe_hi_n | input | 1 | Enable for bits 11..4, active low |
| oe_lo_n | input | 1 | Enable for bits 3..0, active low |
| data_out | output | 12 | Latched result bus |
| data_oe | output | 12 | Per-bit drive enable for data_out |

## Verification
The hardest state to reach is the parked period 2, followed by a resumption that skips straight to period 3. It occurs only when start is high on exactly the edge that ends period 1. The stimulus reaches it by letting a free-running conversion finish, raising start right after the capture edge, and holding the sequencer parked for several edges. Start is then dropped for one edge and raised again, so that the rest of the conversion must run on its own. The same approach is repeated with the external clock source selected. Start is also toggled in the middle of conversions to show that it is ignored there.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic {
    CLK_INTERNAL = 1'b0,
    CLK_EXTERNAL = 1'b1
  } clk_src_e;

  function automatic int cycle_len(input int track_periods, input int nbits);
    return track_periods + nbits;
  endfunction

endpackage

// File: rtl/sar_phase_ctr.sv
module sar_phase_ctr #(
  parameter int CYCLE = 15,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  output logic [PW-1:0] period,
  output logic          halted
);

  localparam logic [PW-1:0] P_FIRST  = PW'(1);
  localparam logic [PW-1:0] P_PARK   = PW'(2);
  localparam logic [PW-1:0] P_RESUME = PW'(3);
  localparam logic [PW-1:0] P_LAST   = PW'(CYCLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= P_FIRST;
      halted <= 1'b0;
    end else if (halted) begin
      if (!start_n) begin
        halted <= 1'b0;
        period <= P_RESUME;
      end
    end else if (period == P_LAST) begin
      period <= P_FIRST;
    end else if (period == P_FIRST) begin
      period <= P_PARK;
      halted <= start_n;
    end else begin
      period <= period + PW'(1);
    end
  end

  // R1: wrap after the last period
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (period == P_LAST) |=> (period == P_FIRST));

  // R12: mid-cycle periods advance regardless of start
  a_r12_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && period != P_FIRST && period != P_LAST) |=>
      (period == $past(period) + PW'(1)));

  // R7: parking only happens in period 2
  a_r7_park_in_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (period == P_PARK));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int NBITS = 12,
  parameter int CYCLE = 15,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             resolve,
  input  logic [PW-1:0]    period,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] word_now
);

  localparam logic [NBITS-1:0] MSB_ONLY = NBITS'(1) << (NBITS - 1);

  logic [PW-1:0]    bit_idx;
  logic [NBITS-1:0] nxt;

  assign bit_idx = PW'(CYCLE) - period;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign word_now[i] = (resolve && bit_idx == PW'(i)) ? cmp_hi : trial[i];
    assign nxt[i]      = word_now[i] | (resolve && bit_idx == PW'(i + 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       trial <= '0;
    else if (load)    trial <= MSB_ONLY;
    else if (resolve) trial <= nxt;
  end

  // R3: the first trial presents only the top bit
  a_r3_msb_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (trial == MSB_ONLY));

endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
  parameter int NBITS    = 12,
  parameter int LO_WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             conv_go,
  input  logic [NBITS-1:0] word_in,
  input  logic             oe_hi_n,
  input  logic             oe_lo_n,
  output logic [NBITS-1:0] word,
  output logic             drdy,
  output logic [NBITS-1:0] oe
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      drdy <= 1'b0;
    end else begin
      if (capture) word <= word_in;
      if (capture)      drdy <= 1'b1;
      else if (conv_go) drdy <= 1'b0;
    end
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_oe
    if (i < LO_WIDTH) begin : g_lo
      assign oe[i] = ~oe_lo_n;
    end else begin : g_hi
      assign oe[i] = ~oe_hi_n;
    end
  end

  // R5: latch changes only on capture
  a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(word));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int NBITS         = 12,
  parameter int TRACK_PERIODS = 3,
  parameter int LO_WIDTH      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             clk_src_ext,
  input  logic             cmp_hi,
  output logic             track_en,
  output logic             autozero_en,
  output logic [NBITS-1:0] cap_sel,
  output logic             clk_run,
  output logic             data_rdy,
  input  logic             oe_hi_n,
  input  logic             oe_lo_n,
  output logic [NBITS-1:0] data_out,
  output logic [NBITS-1:0] data_oe
);

  localparam int CYCLE = cycle_len(TRACK_PERIODS, NBITS);
  localparam int PW    = $clog2(CYCLE + 1);

  logic [PW-1:0]    period;
  logic             halted;
  logic             load, resolve, capture, conv_go;
  logic [NBITS-1:0] trial, word_now;

  assign load     = (period == PW'(TRACK_PERIODS)) && !halted;
  assign resolve  = (period > PW'(TRACK_PERIODS));
  assign capture  = (period == PW'(CYCLE));
  assign conv_go  = !start_n && (halted || period == PW'(1));

  assign track_en    = (period <= PW'(TRACK_PERIODS));
  assign autozero_en = track_en;
  assign cap_sel     = resolve ? trial : '0;
  assign clk_run     = !(halted && clk_src_e'(clk_src_ext) == CLK_INTERNAL);

  sar_phase_ctr #(.CYCLE(CYCLE), .PW(PW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .period  (period),
    .halted  (halted)
  );

  sar_trial_reg #(.NBITS(NBITS), .CYCLE(CYCLE), .PW(PW)) u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .resolve  (resolve),
    .period   (period),
    .cmp_hi   (cmp_hi),
    .trial    (trial),
    .word_now (word_now)
  );

  sar_out_stage #(.NBITS(NBITS), .LO_WIDTH(LO_WIDTH)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .conv_go (conv_go),
    .word_in (word_now),
    .oe_hi_n (oe_hi_n),
    .oe_lo_n (oe_lo_n),
    .word    (data_out),
    .drdy    (data_rdy),
    .oe      (data_oe)
  );

  // R6: data-ready only rises after the last period
  a_r6_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> ($past(period) == PW'(CYCLE)));

  // R7: parked with start high keeps the ready flag
  a_r7_halt_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && start_n) |=> $stable(data_rdy));

  // R8: leaving the parked state always lands in period 3
  a_r8_resume_three: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> (period == PW'(3)));

endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;

  localparam int N = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start_n = 1'b0, clk_src_ext = 1'b0;
  logic oe_hi_n = 1'b0, oe_lo_n = 1'b0;
  logic [N-1:0] analog = '0;
  logic cmp_hi;
  logic track_en, autozero_en, clk_run, data_rdy;
  logic [N-1:0] cap_sel, data_out, data_oe;

  assign cmp_hi = (cap_sel <= analog);

  sar_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .clk_src_ext(clk_src_ext),
    .cmp_hi(cmp_hi), .track_en(track_en), .autozero_en(autozero_en),
    .cap_sel(cap_sel), .clk_run(clk_run), .data_rdy(data_rdy),
    .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .data_out(data_out), .data_oe(data_oe)
  );

  int total = 0, bad = 0;

  localparam logic [N-1:0] CODES [8] = '{
    12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'h001, 12'hFFE, 12'hA5A, 12'h3C3
  };

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] prev;
    analog = CODES[0];
    repeat (3) tick;
    // R11 reset state
    chk("R11 drdy", int'(data_rdy), 0);
    chk("R11 latch", int'(data_out), 0);
    chk("R11 track", int'(track_en), 1);
    chk("R11 clk_run", int'(clk_run), 1);
    rst_n = 1'b1;
    prev = '0;

    // free-running vector table
    for (int e = 0; e < 8; e++) begin
      analog = CODES[e];
      for (int k = 1; k <= 15; k++) begin
        tick;
        if (k < 15) begin
          chk("R6 drdy low", int'(data_rdy), 0);
          chk("R5 latch held", int'(data_out), int'(prev));
        end
        if (k == 1 || k == 2) begin
          chk("R2 track", int'(track_en & autozero_en), 1);
          chk("R2 cap_sel", int'(cap_sel), 0);
        end
        if (k == 3) begin
          chk("R3 track off", int'(track_en), 0);
          chk("R3 msb trial", int'(cap_sel), 'h800);
        end
        if (k == 4)
          chk("R3 msb kept", int'(cap_sel), int'((CODES[e] & 12'h800) | 12'h400));
        if (k == 15) begin
          chk("R1 drdy rise", int'(data_rdy), 1);
          chk(e % 2 == 1 ? "R12 start ignored" : "R4 result", int'(data_out), int'(CODES[e]));
        end
        if (e % 2 == 1 && k <= 13) start_n = k[0];
        if (k == 14) start_n = 1'b0;
      end
      prev = CODES[e];
    end

    // single shot, internal clock
    start_n = 1'b1;
    tick;
    chk("R7 clk_run low", int'(clk_run), 0);
    chk("R7 drdy held", int'(data_rdy), 1);
    chk("R7 tracking", int'(track_en), 1);
    repeat (4) tick;
    chk("R7 still parked", int'(clk_run), 0);
    chk("R7 latch", int'(data_out), int'(prev));
    analog = 12'h5A3;
    start_n = 1'b0;
    tick;
    chk("R8 drdy cleared", int'(data_rdy), 0);
    chk("R8 clk_run", int'(clk_run), 1);
    chk("R8 period3 track", int'(track_en), 1);
    start_n = 1'b1;
    tick;
    chk("R8 trial start", int'(cap_sel), 'h800);
    repeat (11) tick;
    chk("R8 not yet", int'(data_rdy), 0);
    tick;
    chk("R8 drdy", int'(data_rdy), 1);
    chk("R8 result", int'(data_out), 'h5A3);

    // single shot, external clock
    tick;
    chk("R7 parked again", int'(clk_run), 0);
    clk_src_ext = 1'b1;
    #1;
    chk("R9 clk_run ext", int'(clk_run), 1);
    chk("R9 drdy", int'(data_rdy), 1);
    analog = 12'h0F1;
    start_n = 1'b0;
    tick;
    chk("R9 resume drdy", int'(data_rdy), 0);
    chk("R9 track", int'(track_en), 1);
    repeat (12) tick;
    chk("R9 not yet", int'(data_rdy), 0);
    tick;
    chk("R9 result", int'(data_out), 'h0F1);

    // output enables
    oe_hi_n = 1'b1; oe_lo_n = 1'b0; #1;
    chk("R10 lo only", int'(data_oe), 'h00F);
    oe_hi_n = 1'b0; oe_lo_n = 1'b1; #1;
    chk("R10 hi only", int'(data_oe), 'hFF0);
    oe_hi_n = 1'b1; oe_lo_n = 1'b1; #1;
    chk("R10 none", int'(data_oe), 0);
    oe_hi_n = 1'b0; oe_lo_n = 1'b0; #1;
    chk("R10 all", int'(data_oe), 'hFFF);
    chk("R10 bus", int'(data_out), 'h0F1);

    // reset in mid conversion
    repeat (5) tick;
    rst_n = 1'b0;
    tick;
    chk("R11 mid reset latch", int'(data_out), 0);
    chk("R11 mid reset drdy", int'(data_rdy), 0);
    chk("R11 mid reset track", int'(track_en), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule